// File: doc/BRIEF.md
# SPI NOR Flash Command Sequencer

This block is the master side of a serial NOR flash link. A host hands it one command at a time: a command kind, a 24-bit address, a byte count, and a stream of write bytes where the command needs them. The block turns that request into a single chip-select frame on the SPI pins. Each frame carries an opcode byte first. Address bytes, a dummy byte and data bytes follow where the command kind calls for them. Bytes that the flash returns come back to the host on a valid/ready stream.

The command kind decides the shape of the frame. The fast array read inserts one dummy byte after the address. The slow array read does not, and it runs SCK at half the normal rate. Busy polling sends the status opcode once. It then keeps clocking status bytes inside the same frame until the busy bit reads clear, and it returns only that final status byte. After chip select goes high, the block holds it high for a set number of cycles, then emits a one-cycle done pulse and accepts the next command. Both SPI mode 0 and mode 3 are supported, selected by a pin, and data is shifted MSB first.

Top module: `spinor_seq`

## Requirements
- R1: Every command that performs a transaction produces exactly one frame: chip select low, the opcode byte, the command-specific bytes, then chip select high. The kind codes map to these opcodes: 0 fast read 0x0B, 1 slow read 0x03, 2 program 0x02, 3 erase 4 KB 0x20, 4 erase 32 KB 0x52, 5 erase 64 KB 0xD8, 6 chip erase 0x60, 7 write enable 0x06, 8 write disable 0x04, 9 status read 0x05, 10 status write 0x01, 11 identification read 0x9F, 12 busy poll 0x05.
- R2: Kinds 0 to 5 send the 24-bit address as three bytes right after the opcode, most significant byte first. No other kind sends an address.
- R3: A fast read (kind 0) sends one dummy byte of value 0xFF between the address and the data. A slow read (kind 1) goes straight from the address to the data.
- R4: SCK rests at the level of `cfg_mode3` whenever chip select is high (low in mode 0, high in mode 3). MOSI changes only while SCK is low, and MISO is sampled on the SCK rising edge. Bytes go out MSB first.
- R5: In a read phase, MOSI carries 0x00. Every byte received in that phase appears on the read stream in order. A byte is held stable until `rd_ready` accepts it, and no further read byte is clocked while one is pending.
- R6: Program (kind 2) takes `cmd_len` bytes from the write stream and shifts them out after the address. Status write (kind 10) takes exactly one byte from the write stream.
- R7: Status read (kind 9) returns one byte, and identification read (kind 11) returns three bytes, whatever `cmd_len` holds.
- R8: Busy poll (kind 12) is one frame: the opcode, then status bytes until one has bit 0 clear. Only that final byte is returned on the read stream.
- R9: A read or program request (kinds 0 to 2) with `cmd_len` equal to 0, and any kind code from 13 to 15, performs no transaction. Chip select never falls, no write byte is taken, and done still follows.
- R10: SCK high and low phases each last `SCK_HALF` clock cycles. For the slow read they each last 2*`SCK_HALF` cycles.
- R11: `cmd_ready` is high only while the block is idle. `done` is a one-cycle pulse that rises after chip select has been high for `CS_GAP` cycles at the end of a command.
- R12: After reset, chip select is high, SCK sits at the mode level, `cmd_ready` is high, and `rd_valid`, `wr_ready` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode3 | input | 1 | 0 selects SPI mode 0, 1 selects mode 3 |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle; command taken when both high |
| cmd_kind | input | 4 | Command kind code (see R1) |
| cmd_addr | input | 24 | Flash byte address |
| cmd_len | input | LEN_W | Data byte count for read and program |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken when both high |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host accepts the read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The embedded assertions check the properties that must hold on every clock cycle:
- SCK rests at the mode level whenever chip select is high.
- MOSI is steady at each SCK rise.
- A pending read byte is held stable under back-pressure.
- `cmd_ready` never rises inside a frame.
- `done` lasts one cycle and only follows a high chip select.
- A zero-length request keeps chip select high.

Only the bench scenarios can show the content of each frame. That covers the opcode per kind, the byte order of the address, the presence or absence of the dummy byte, the number of polled status bytes, the returned data values, the two SCK rates and the exact chip-select gap. To check these, the bench compares a bit-level flash model against byte sequences it computes from the requirements.

// File: rtl/spinor_pkg.sv
// Shared types and command decode for the SPI NOR command sequencer.
// Assumes 24-bit flash addressing and one opcode byte per frame.
package spinor_pkg;

    localparam int ADDR_W = 24;
    localparam logic [7:0] DUMMY_FILL = 8'hFF;
    localparam logic [7:0] READ_FILL  = 8'h00;
    localparam int BUSY_BIT = 0;

    typedef enum logic [3:0] {
        K_FAST_RD = 4'd0,
        K_SLOW_RD = 4'd1,
        K_PROG    = 4'd2,
        K_ER4K    = 4'd3,
        K_ER32K   = 4'd4,
        K_ER64K   = 4'd5,
        K_ERCHIP  = 4'd6,
        K_WREN    = 4'd7,
        K_WRDIS   = 4'd8,
        K_RDSTAT  = 4'd9,
        K_WRSTAT  = 4'd10,
        K_RDID    = 4'd11,
        K_POLL    = 4'd12
    } cmd_kind_e;

    typedef enum logic [1:0] {
        D_NONE  = 2'd0,
        D_READ  = 2'd1,
        D_WRITE = 2'd2,
        D_POLL  = 2'd3
    } data_dir_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] opcode;
        logic       has_addr;
        logic       has_dummy;
        logic       slow;
        data_dir_e  dir;
        logic       len_from_host;
        logic [1:0] fixed_len;
    } frame_shape_t;

    // Map a command kind onto the shape of its SPI frame.
    function automatic frame_shape_t decode_kind(input logic [3:0] kind);
        frame_shape_t s;
        s = '{valid: 1'b1, opcode: 8'h00, has_addr: 1'b0, has_dummy: 1'b0,
              slow: 1'b0, dir: D_NONE, len_from_host: 1'b0, fixed_len: 2'd0};
        case (kind)
            K_FAST_RD: begin s.opcode = 8'h0B; s.has_addr = 1'b1; s.has_dummy = 1'b1;
                             s.dir = D_READ; s.len_from_host = 1'b1; end
            K_SLOW_RD: begin s.opcode = 8'h03; s.has_addr = 1'b1; s.slow = 1'b1;
                             s.dir = D_READ; s.len_from_host = 1'b1; end
            K_PROG:    begin s.opcode = 8'h02; s.has_addr = 1'b1;
                             s.dir = D_WRITE; s.len_from_host = 1'b1; end
            K_ER4K:    begin s.opcode = 8'h20; s.has_addr = 1'b1; end
            K_ER32K:   begin s.opcode = 8'h52; s.has_addr = 1'b1; end
            K_ER64K:   begin s.opcode = 8'hD8; s.has_addr = 1'b1; end
            K_ERCHIP:  s.opcode = 8'h60;
            K_WREN:    s.opcode = 8'h06;
            K_WRDIS:   s.opcode = 8'h04;
            K_RDSTAT:  begin s.opcode = 8'h05; s.dir = D_READ;  s.fixed_len = 2'd1; end
            K_WRSTAT:  begin s.opcode = 8'h01; s.dir = D_WRITE; s.fixed_len = 2'd1; end
            K_RDID:    begin s.opcode = 8'h9F; s.dir = D_READ;  s.fixed_len = 2'd3; end
            K_POLL:    begin s.opcode = 8'h05; s.dir = D_POLL; end
            default:   s.valid = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/spinor_byte_shifter.sv
// One-byte SPI shift engine. It runs 8 SCK periods per start pulse.
// MOSI changes while SCK is low and MISO is sampled at each rising edge,
// which serves both mode 0 and mode 3. Assumes half_div >= 1 and
// that half_div and cpol stay constant while a byte is in flight.
module spinor_byte_shifter #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpol,
    input  logic [DIV_W-1:0] half_div,
    input  logic             start,
    input  logic [7:0]       tx_byte,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    localparam int PH_LAST = 15;

    logic             active;
    logic [3:0]       ph;
    logic [DIV_W-1:0] hcnt;
    logic [7:0]       tx_sr;
    logic [7:0]       rx_sr;

    // SCK follows the phase LSB during a byte and rests at the idle level otherwise.
    assign sck     = active ? ph[0] : cpol;
    assign mosi    = tx_sr[7];
    assign rx_byte = rx_sr;

    // Advance half-periods, sample on rising, shift on falling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            ph        <= '0;
            hcnt      <= '0;
            tx_sr     <= '0;
            rx_sr     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                ph     <= '0;
                hcnt   <= '0;
                tx_sr  <= tx_byte;
            end else if (active) begin
                if (hcnt == half_div - DIV_W'(1)) begin
                    hcnt <= '0;
                    ph   <= ph + 4'd1;
                    if (!ph[0]) begin
                        rx_sr <= {rx_sr[6:0], miso};
                    end else if (ph == 4'(PH_LAST)) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        tx_sr <= {tx_sr[6:0], 1'b0};
                    end
                end else begin
                    hcnt <= hcnt + DIV_W'(1);
                end
            end
        end
    end

    AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $rose(sck)) |-> $stable(mosi)); // R4

    AST_ONE_BYTE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !active); // R1

endmodule

// File: rtl/spinor_rd_slot.sv
// Single-entry holding register for bytes returned to the host.
// Assumes the producer only pushes while the slot is empty.
module spinor_rd_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    output logic       rd_valid,
    input  logic       rd_ready,
    output logic [7:0] rd_data,
    output logic       slot_busy
);
    assign slot_busy = rd_valid;

    // Fill on push, empty on host acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (push) begin
            rd_valid <= 1'b1;
            rd_data  <= push_data;
        end else if (rd_valid && rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5

    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !rd_valid); // R5

endmodule

// File: rtl/spinor_frame_ctl.sv
// Frame sequencer. It accepts one command while idle, walks the phases
// opcode, address, dummy and data, and issues one byte at a time to the shifter.
// It closes the frame, times the chip-select gap and pulses done.
// Assumes CS_GAP >= 1 and SCK_HALF >= 1.
module spinor_frame_ctl
    import spinor_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int SCK_HALF = 2,
    parameter int CS_GAP   = 4,
    parameter int DIV_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [3:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    input  logic              slot_busy,
    output logic              push,
    output logic [7:0]        push_data,
    output logic              sh_start,
    output logic [7:0]        sh_byte,
    output logic [DIV_W-1:0]  sh_half,
    input  logic              sh_done,
    input  logic [7:0]        sh_rx,
    output logic              cs_n,
    output logic              done
);
    localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_SHIFT, S_GAP} st_e;
    typedef enum logic [1:0] {G_OPC, G_ADDR, G_DUMMY, G_DATA} stage_e;

    st_e               st;
    stage_e            stg, nxt_stg;
    frame_shape_t      dec;
    logic              skip;
    logic [7:0]        op_q;
    logic              addr_en_q, dummy_q, slow_q;
    data_dir_e         dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  dlen_q, cnt, nxt_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              go, last;

    assign dec       = decode_kind(cmd_kind);
    assign skip      = !dec.valid || (dec.len_from_host && (cmd_len == '0));
    assign cmd_ready = (st == S_IDLE);
    assign sh_half   = slow_q ? DIV_W'(2 * SCK_HALF) : DIV_W'(SCK_HALF);
    assign sh_start  = go;
    assign push_data = sh_rx;
    assign push      = (st == S_SHIFT) && sh_done && (stg == G_DATA) &&
                       ((dir_q == D_READ) || ((dir_q == D_POLL) && !sh_rx[BUSY_BIT]));

    // Choose the next outgoing byte and decide whether it can launch now.
    always_comb begin
        sh_byte  = READ_FILL;
        go       = 1'b0;
        wr_ready = 1'b0;
        if (st == S_LAUNCH) begin
            case (stg)
                G_OPC: begin
                    sh_byte = op_q;
                    go      = 1'b1;
                end
                G_ADDR: begin
                    case (cnt[1:0])
                        2'd0:    sh_byte = addr_q[23:16];
                        2'd1:    sh_byte = addr_q[15:8];
                        default: sh_byte = addr_q[7:0];
                    endcase
                    go = 1'b1;
                end
                G_DUMMY: begin
                    sh_byte = DUMMY_FILL;
                    go      = 1'b1;
                end
                default: begin
                    if (dir_q == D_WRITE) begin
                        wr_ready = 1'b1;
                        sh_byte  = wr_data;
                        go       = wr_valid;
                    end else begin
                        go = !slot_busy;
                    end
                end
            endcase
        end
    end

    // Work out the phase that follows a finished byte and whether the frame ends.
    always_comb begin
        nxt_stg = stg;
        nxt_cnt = cnt;
        last    = 1'b0;
        case (stg)
            G_OPC: begin
                if (addr_en_q) begin
                    nxt_stg = G_ADDR;
                    nxt_cnt = '0;
                end else if (dir_q != D_NONE) begin
                    nxt_stg = G_DATA;
                    nxt_cnt = '0;
                end else begin
                    last = 1'b1;
                end
            end
            G_ADDR: begin
                if (cnt != LEN_W'(2)) begin
                    nxt_cnt = cnt + LEN_W'(1);
                end else if (dummy_q) begin
                    nxt_stg = G_DUMMY;
                end else if (dir_q != D_NONE) begin
                    nxt_stg = G_DATA;
                    nxt_cnt = '0;
                end else begin
                    last = 1'b1;
                end
            end
            G_DUMMY: begin
                nxt_stg = G_DATA;
                nxt_cnt = '0;
            end
            default: begin
                if (dir_q == D_POLL) begin
                    last = !sh_rx[BUSY_BIT];
                end else if (cnt == dlen_q - LEN_W'(1)) begin
                    last = 1'b1;
                end else begin
                    nxt_cnt = cnt + LEN_W'(1);
                end
            end
        endcase
    end

    // Main state register: accept, launch, shift, gap, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            stg       <= G_OPC;
            cnt       <= '0;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            gap_cnt   <= '0;
            op_q      <= '0;
            addr_en_q <= 1'b0;
            dummy_q   <= 1'b0;
            slow_q    <= 1'b0;
            dir_q     <= D_NONE;
            addr_q    <= '0;
            dlen_q    <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q      <= dec.opcode;
                        addr_en_q <= dec.has_addr;
                        dummy_q   <= dec.has_dummy;
                        slow_q    <= dec.slow;
                        dir_q     <= dec.dir;
                        addr_q    <= cmd_addr;
                        dlen_q    <= dec.len_from_host ? cmd_len : LEN_W'(dec.fixed_len);
                        gap_cnt   <= '0;
                        stg       <= G_OPC;
                        cnt       <= '0;
                        if (skip) begin
                            st <= S_GAP;
                        end else begin
                            cs_n <= 1'b0;
                            st   <= S_LAUNCH;
                        end
                    end
                end
                S_LAUNCH: begin
                    if (go) st <= S_SHIFT;
                end
                S_SHIFT: begin
                    if (sh_done) begin
                        if (last) begin
                            cs_n    <= 1'b1;
                            gap_cnt <= '0;
                            st      <= S_GAP;
                        end else begin
                            stg <= nxt_stg;
                            cnt <= nxt_cnt;
                            st  <= S_LAUNCH;
                        end
                    end
                end
                default: begin
                    if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
                        done <= 1'b1;
                        st   <= S_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
            endcase
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !cmd_ready); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && $past(cs_n))); // R11

    AST_ZERO_LEN_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && (cmd_kind <= 4'd2) && (cmd_len == '0)) |=> cs_n); // R9

endmodule

// File: rtl/spinor_seq.sv
// Top of the SPI NOR command sequencer. It joins the frame sequencer,
// the byte shift engine and the read holding slot. cfg_mode3 must only
// change while the block is idle.
module spinor_seq #(
    parameter int LEN_W    = 16,
    parameter int SCK_HALF = 2,
    parameter int CS_GAP   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode3,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0]       cmd_kind,
    input  logic [23:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    localparam int DIV_W = $clog2(2 * SCK_HALF + 1);

    logic             sh_start, sh_done, push, slot_busy;
    logic [7:0]       sh_byte, sh_rx, push_data;
    logic [DIV_W-1:0] sh_half;

    spinor_frame_ctl #(
        .LEN_W(LEN_W), .SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP), .DIV_W(DIV_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .slot_busy(slot_busy), .push(push), .push_data(push_data),
        .sh_start(sh_start), .sh_byte(sh_byte), .sh_half(sh_half),
        .sh_done(sh_done), .sh_rx(sh_rx),
        .cs_n(spi_cs_n), .done(done)
    );

    spinor_byte_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cpol(cfg_mode3), .half_div(sh_half),
        .start(sh_start), .tx_byte(sh_byte), .byte_done(sh_done), .rx_byte(sh_rx),
        .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

    spinor_rd_slot u_slot (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .slot_busy(slot_busy)
    );

    AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sck == cfg_mode3)); // R4

    AST_NO_WRITE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !wr_ready); // R9

endmodule

// File: tb/tb_spinor_seq.sv
`timescale 1ns/1ps
module tb_spinor_seq;
    localparam int LEN_W    = 16;
    localparam int SCK_HALF = 2;
    localparam int CS_GAP   = 4;
    localparam int NVEC     = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_mode3 = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [3:0] cmd_kind = '0;
    logic [23:0] cmd_addr = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic wr_valid = 1'b1;
    logic wr_ready;
    logic [7:0] wr_data;
    logic rd_valid;
    logic rd_ready = 1'b1;
    logic [7:0] rd_data;
    logic done;
    logic spi_cs_n, spi_sck, spi_mosi, spi_miso;

    always #2.5 clk = ~clk;

    spinor_seq #(.LEN_W(LEN_W), .SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode3(cfg_mode3),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done(done), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int tests = 0;
    int fails = 0;

    // ---------------- flash model: bit level, returns a known pattern
    int s_nbytes = 0;
    int s_bitc = 0;
    int s_frames = 0;
    int busy_lim = 0;
    logic [7:0] s_bytes [0:63];
    logic [7:0] s_sh = '0;
    logic s_idle_lvl = 1'b0;
    realtime t_first = 0;
    realtime s_period = 0;

    function automatic logic [7:0] ret_byte(input int i, input int blim);
        logic [6:0] h;
        h = 7'(i + 64);
        return {h, (i < blim)};
    endfunction

    logic [7:0] s_out;
    assign s_out = ret_byte(s_nbytes, busy_lim);
    assign spi_miso = s_out[3'(7 - s_bitc)];

    always @(negedge spi_cs_n) begin
        s_nbytes = 0;
        s_bitc = 0;
        s_frames = s_frames + 1;
        s_idle_lvl = spi_sck;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (s_nbytes == 0 && s_bitc == 0) t_first = $realtime;
            if (s_nbytes == 0 && s_bitc == 1) s_period = $realtime - t_first;
            s_sh = {s_sh[6:0], spi_mosi};
            s_bitc = s_bitc + 1;
            if (s_bitc == 8) begin
                if (s_nbytes < 64) s_bytes[s_nbytes] = s_sh;
                s_nbytes = s_nbytes + 1;
                s_bitc = 0;
            end
        end
    end

    // ---------------- host streams
    int wr_cnt = 0;
    int wr_base = 0;
    assign wr_data = 8'hC0 + 8'(wr_cnt - wr_base);
    always @(posedge clk) if (wr_valid && wr_ready) wr_cnt <= wr_cnt + 1;

    int rd_cnt = 0;
    logic [7:0] rd_buf [0:63];
    always @(posedge clk) if (rd_valid && rd_ready) begin
        rd_buf[rd_cnt[5:0]] <= rd_data;
        rd_cnt <= rd_cnt + 1;
    end

    logic bp_en = 1'b0;
    always @(negedge clk) rd_ready <= bp_en ? ~rd_ready : 1'b1;

    // ---------------- watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog R11: act=%0d cycles exp<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- expected frame, built from the requirements
    function automatic logic [7:0] b_opc(input int k);
        case (k)
            0: return 8'h0B;  1: return 8'h03;  2: return 8'h02;  3: return 8'h20;
            4: return 8'h52;  5: return 8'hD8;  6: return 8'h60;  7: return 8'h06;
            8: return 8'h04;  9: return 8'h05; 10: return 8'h01; 11: return 8'h9F;
            default: return 8'h05;
        endcase
    endfunction
    function automatic int b_hdr(input int k);
        return 1 + ((k <= 5) ? 3 : 0) + ((k == 0) ? 1 : 0);
    endfunction
    function automatic int b_dlen(input int k, input int len);
        if (k <= 2) return len;
        if (k == 9 || k == 10) return 1;
        if (k == 11) return 3;
        return 0;
    endfunction
    function automatic int b_rdn(input int k, input int len);
        if (k <= 1) return len;
        if (k == 9) return 1;
        if (k == 11) return 3;
        return 0;
    endfunction
    function automatic logic [7:0] exp_mosi(input int k, input logic [23:0] a, input int j);
        if (j == 0) return b_opc(k);
        if (k <= 5 && j < 4) return 8'(a >> (8 * (3 - j)));
        if (k == 0 && j == 4) return 8'hFF;
        if (k == 2 || k == 10) return 8'hC0 + 8'(j - b_hdr(k));
        return 8'h00;
    endfunction

    int gap_seen, done_w, ready_bad, f0, rb, got_done;

    task automatic run_cmd(input int k, input logic [23:0] a, input int len,
                           input bit mode, input bit bp);
        @(negedge clk);
        cfg_mode3 = mode;
        bp_en = bp;
        f0 = s_frames;
        rb = rd_cnt;
        wr_base = wr_cnt;
        cmd_kind = 4'(k);
        cmd_addr = a;
        cmd_len = LEN_W'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        gap_seen = 0;
        ready_bad = 0;
        got_done = 0;
        for (int n = 0; n < 20000; n++) begin
            if (done) begin
                got_done = 1;
                break;
            end
            if (!spi_cs_n && cmd_ready) ready_bad = 1;
            if (spi_cs_n) gap_seen = gap_seen + 1; else gap_seen = 0;
            @(negedge clk);
        end
        @(negedge clk);
        done_w = done ? 2 : 1;
        repeat (6) @(negedge clk);
        bp_en = 1'b0;
        chk(got_done == 1, "R11 done seen", got_done, 1);
        chk(done_w == 1, "R11 done width", done_w, 1);
        chk(gap_seen == CS_GAP, "R11 cs gap", gap_seen, CS_GAP);
        chk(ready_bad == 0, "R11 ready in frame", ready_bad, 0);
    endtask

    task automatic check_frame(input int k, input logic [23:0] a, input int len, input bit mode);
        int flen, bad, bi, nrd;
        flen = b_hdr(k) + b_dlen(k, len);
        chk(s_frames - f0 == 1, "R1 one frame", s_frames - f0, 1);
        chk(s_nbytes == flen, "R1 R2 R3 R6 R7 frame length", s_nbytes, flen);
        bad = 0; bi = 0;
        for (int j = 0; j < flen && j < 64; j++)
            if (bad == 0 && s_bytes[j] !== exp_mosi(k, a, j)) begin bad = 1; bi = j; end
        chk(bad == 0, "R1 R2 R3 R6 frame byte", int'(s_bytes[bi]), int'(exp_mosi(k, a, bi)));
        chk(s_idle_lvl == mode, "R4 sck idle level", s_idle_lvl, mode);
        nrd = b_rdn(k, len);
        chk(rd_cnt - rb == nrd, "R5 R7 read count", rd_cnt - rb, nrd);
        bad = 0; bi = 0;
        for (int j = 0; j < nrd; j++)
            if (bad == 0 && rd_buf[6'(rb + j)] !== ret_byte(b_hdr(k) + b_dlen(k,len) - nrd + j, 0)) begin
                bad = 1; bi = j;
            end
        chk(bad == 0, "R5 R7 read data", int'(rd_buf[6'(rb + bi)]),
            int'(ret_byte(b_hdr(k) + b_dlen(k,len) - nrd + bi, 0)));
        chk(s_period == ((k == 1) ? 40.0 : 20.0), "R10 sck period ns",
            int'(s_period), (k == 1) ? 40 : 20);
    endtask

    // kind, address, length, mode
    localparam logic [44:0] VECS [0:NVEC-1] = '{
        {4'd0,  24'h123456, 16'd4, 1'b0},
        {4'd1,  24'hABCDEF, 16'd3, 1'b1},
        {4'd2,  24'h0000FE, 16'd4, 1'b0},
        {4'd3,  24'h001034, 16'd0, 1'b1},
        {4'd4,  24'h7F8001, 16'd0, 1'b0},
        {4'd5,  24'h3C0000, 16'd0, 1'b0},
        {4'd6,  24'h000000, 16'd0, 1'b1},
        {4'd7,  24'h000000, 16'd0, 1'b0},
        {4'd8,  24'h000000, 16'd0, 1'b1},
        {4'd9,  24'h000000, 16'd7, 1'b0},
        {4'd10, 24'h000000, 16'd0, 1'b1},
        {4'd11, 24'h000000, 16'd0, 1'b0},
        {4'd0,  24'hFFFFFF, 16'd1, 1'b1}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(spi_cs_n == 1'b1, "R12 cs_n", spi_cs_n, 1);
        chk(spi_sck == 1'b0, "R12 sck", spi_sck, 0);
        chk(cmd_ready == 1'b1, "R12 cmd_ready", cmd_ready, 1);
        chk(rd_valid == 1'b0 && wr_ready == 1'b0 && done == 1'b0, "R12 flags",
            {rd_valid, wr_ready, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            int k, len;
            logic [23:0] a;
            bit m;
            k = int'(VECS[v][44:41]);
            a = VECS[v][40:17];
            len = int'(VECS[v][16:1]);
            m = VECS[v][0];
            run_cmd(k, a, len, m, 1'b0);
            check_frame(k, a, len, m);
        end

        // R8 busy poll: three busy status bytes, then ready
        busy_lim = 4;
        run_cmd(12, 24'h0, 0, 1'b0, 1'b0);
        chk(s_frames - f0 == 1, "R8 poll one frame", s_frames - f0, 1);
        chk(s_nbytes == 5, "R8 poll status bytes", s_nbytes, 5);
        chk(s_bytes[0] == 8'h05 && s_bytes[4] == 8'h00, "R8 poll mosi",
            {s_bytes[0], s_bytes[4]}, 16'h0500);
        chk(rd_cnt - rb == 1, "R8 poll returns one", rd_cnt - rb, 1);
        chk(rd_buf[6'(rb)] == 8'h88, "R8 poll final status", rd_buf[6'(rb)], 8'h88);
        busy_lim = 0;

        // R9 zero length and unused kind codes
        run_cmd(0, 24'h111111, 0, 1'b0, 1'b0);
        chk(s_frames - f0 == 0, "R9 zero-len read no frame", s_frames - f0, 0);
        chk(rd_cnt - rb == 0, "R9 zero-len read no data", rd_cnt - rb, 0);
        run_cmd(2, 24'h222222, 0, 1'b1, 1'b0);
        chk(s_frames - f0 == 0, "R9 zero-len program no frame", s_frames - f0, 0);
        chk(wr_cnt - wr_base == 0, "R9 zero-len program no write", wr_cnt - wr_base, 0);
        run_cmd(14, 24'h333333, 5, 1'b0, 1'b0);
        chk(s_frames - f0 == 0, "R9 unused kind no frame", s_frames - f0, 0);

        // R5 read back-pressure, mode 3
        run_cmd(0, 24'h0A0B0C, 6, 1'b1, 1'b1);
        check_frame(0, 24'h0A0B0C, 6, 1'b1);

        // R6 program consumes exactly len write bytes
        run_cmd(2, 24'h000100, 3, 1'b1, 1'b0);
        chk(wr_cnt - wr_base == 3, "R6 write bytes taken", wr_cnt - wr_base, 3);
        check_frame(2, 24'h000100, 3, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule